// File: doc/BRIEF.md
# Configuration Command Register with Parity Error Response

This block holds the 16-bit command word that a host programs through configuration space. The word turns on memory decoding, bus mastering, write-and-invalidate bursts, back-to-back master cycles, parity error response and system-error signalling. The block also holds the parity-error reporting logic that these enable bits control. The host writes and reads the command word and a small status word through a configuration port with byte enables. A bus engine outside the block reports parity errors as single-cycle pulses. The block answers with registered PERR and SERR strobes and sets sticky status bits. The host clears a status bit by writing 1 to it.

Only a hard reset changes the enable bits. Soft resets and stop requests leave them alone. Three qualifier outputs let the rest of the device gate its behaviour on the enables: a memory decode qualifier, a master permission signal and a write-and-invalidate select.

Top module: `pci_cmd_reg`

## Requirements
- R1: When `rst_n` is low at a clock edge, all writable command bits, all three status bits and both strobes are cleared.
- R2: The writable command bits are 9 (fast back-to-back), 8 (SERR enable), 6 (parity response enable), 4 (write-and-invalidate enable), 2 (bus master enable) and 1 (memory enable). All other bits read as 0 and ignore writes, so writing 0xFFFF reads back as 0x0356.
- R3: A write with `cfg_sel`=0 updates bits 7..0 only when `cfg_be[0]` is 1, and bits 15..8 only when `cfg_be[1]` is 1.
- R4: `soft_rst` and `stop_req` never change any command bit.
- R5: An address or data parity error pulse sets the detected-parity-error status bit (status bit 15) at the next edge, whatever the enables are.
- R6: `perr_o` is high for exactly the one cycle after a `data_perr` pulse, and only if the parity response enable was 1 at that pulse.
- R7: Status bit 8 (data parity reported) is set by a data parity error only if the parity response enable is 1 and `is_master` is 1 with the pulse.
- R8: An address parity error raises `serr_o` for one cycle and sets status bit 14 (signaled system error) only if both the SERR enable and the parity response enable are 1.
- R9: A write with `cfg_sel`=1 and `cfg_be[1]`=1 clears each status bit (15, 14, 8) where the write data holds a 1. A new error in the same cycle wins over the clear. The status word reads through `cfg_rdata` when `cfg_sel`=1, with all other bits 0.
- R10: `mem_decode_ok` equals `mem_hit` AND the memory enable, so memory accesses are ignored while the enable is 0.
- R11: `use_mwi` equals `line_ok` AND the write-and-invalidate enable. Otherwise master writes use plain memory write.
- R12: `master_ok` is high only when the bus master enable is 1 and neither `stop_req` nor `soft_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| soft_rst | input | 1 | Soft reset request |
| stop_req | input | 1 | Stop request from the controller |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the command word, 1 selects the status word |
| cfg_be | input | 2 | Byte enables for a write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the selected word |
| addr_perr | input | 1 | Address parity error pulse |
| data_perr | input | 1 | Data parity error pulse |
| is_master | input | 1 | The current cycle is a master cycle of this device |
| mem_hit | input | 1 | The address decoder matched a memory range of the device |
| line_ok | input | 1 | The pending master write qualifies for write-and-invalidate |
| fbb_en | output | 1 | Fast back-to-back enable |
| serr_en | output | 1 | SERR enable |
| perr_resp_en | output | 1 | Parity response enable |
| mwi_en | output | 1 | Write-and-invalidate enable |
| bm_en | output | 1 | Bus master enable |
| mem_en | output | 1 | Memory space enable |
| mem_decode_ok | output | 1 | Qualified memory decode |
| master_ok | output | 1 | Permission to start master cycles |
| use_mwi | output | 1 | Select write-and-invalidate for the current master write |
| perr_o | output | 1 | PERR strobe, active high |
| serr_o | output | 1 | SERR strobe, active high |
| stat_dpe | output | 1 | Detected parity error status |
| stat_dpr | output | 1 | Data parity reported status |
| stat_sse | output | 1 | Signaled system error status |

## Verification
The assertions check a set of properties on every cycle:
- every PERR or SERR strobe traces back to an error pulse whose enables permitted it;
- every parity error pulse sets the detected bit;
- soft resets and stops without a write leave the enables unchanged;
- the qualifier outputs never rise without their enable.

Some behaviour only the bench scenarios can show: the exact byte-enable merge, the reserved bits reading as zero, the write-1-to-clear clearing and the split of the data-parity-reported bit between master and target cycles. These need known prior contents and chosen data patterns.

// File: rtl/pci_cmd_pkg.sv
// Package: bit positions, write mask and shared types for the
// configuration command register. Assumes a 16-bit configuration word.
package pci_cmd_pkg;
    localparam int CFG_W = 16;
    localparam int BE_W  = CFG_W / 8;

    // Command bit positions (fixed by the configuration layout)
    localparam int B_FBB   = 9;
    localparam int B_SERRE = 8;
    localparam int B_PERE  = 6;
    localparam int B_MWI   = 4;
    localparam int B_BME   = 2;
    localparam int B_MEM   = 1;

    // Status bit positions
    localparam int S_DPR = 8;
    localparam int S_SSE = 14;
    localparam int S_DPE = 15;

    localparam logic [CFG_W-1:0] CMD_WMASK =
        (CFG_W'(1) << B_FBB) | (CFG_W'(1) << B_SERRE) | (CFG_W'(1) << B_PERE) |
        (CFG_W'(1) << B_MWI) | (CFG_W'(1) << B_BME)   | (CFG_W'(1) << B_MEM);

    typedef struct packed {
        logic fbb;
        logic serre;
        logic pere;
        logic mwi;
        logic bme;
        logic mem;
    } cmd_en_t;

    // Expand byte enables into a bit mask
    function automatic logic [CFG_W-1:0] be_mask(input logic [BE_W-1:0] be);
        logic [CFG_W-1:0] m;
        m = '0;
        for (int i = 0; i < BE_W; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction
endpackage

// File: rtl/pci_cmd_regs.sv
// Command word storage. Only the bits in CMD_WMASK hold state; all
// other bits stay zero. Assumes wr_en is already qualified by the
// command-word select. Cleared only by the hard reset.
module pci_cmd_regs
    import pci_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BE_W-1:0]  be,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] word,
    output cmd_en_t          en
);
    logic [CFG_W-1:0] cmd_q;
    logic [CFG_W-1:0] bmask;

    // Bits selected by the byte enables of this write
    always_comb bmask = be_mask(be);

    // Merge the enabled bytes and drop the reserved bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_en) begin
            cmd_q <= ((cmd_q & ~bmask) | (wdata & bmask)) & CMD_WMASK;
        end
    end

    // Present the stored word and the decoded enables
    always_comb begin
        word      = cmd_q;
        en.fbb    = cmd_q[B_FBB];
        en.serre  = cmd_q[B_SERRE];
        en.pere   = cmd_q[B_PERE];
        en.mwi    = cmd_q[B_MWI];
        en.bme    = cmd_q[B_BME];
        en.mem    = cmd_q[B_MEM];
    end
endmodule

// File: rtl/pci_cmd_errlog.sv
// Parity error response: registered PERR/SERR strobes and sticky
// status bits with write-1-to-clear. Assumes error inputs are
// single-cycle pulses. A new error in the same cycle wins over a clear.
module pci_cmd_errlog (
    input  logic clk,
    input  logic rst_n,
    input  logic pere,
    input  logic serre,
    input  logic addr_perr,
    input  logic data_perr,
    input  logic is_master,
    input  logic clr_wr,
    input  logic clr_dpe,
    input  logic clr_sse,
    input  logic clr_dpr,
    output logic perr_o,
    output logic serr_o,
    output logic dpe,
    output logic sse,
    output logic dpr
);
    logic set_dpe, set_sse, set_dpr;

    // Which status bits this cycle's errors raise
    always_comb begin
        set_dpe = addr_perr | data_perr;
        set_sse = addr_perr & serre & pere;
        set_dpr = data_perr & pere & is_master;
    end

    // One-cycle strobes following the error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_o <= 1'b0;
            serr_o <= 1'b0;
        end else begin
            perr_o <= data_perr & pere;
            serr_o <= set_sse;
        end
    end

    // Sticky status with write-1-to-clear, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dpe <= 1'b0;
            sse <= 1'b0;
            dpr <= 1'b0;
        end else begin
            dpe <= set_dpe | (dpe & ~(clr_wr & clr_dpe));
            sse <= set_sse | (sse & ~(clr_wr & clr_sse));
            dpr <= set_dpr | (dpr & ~(clr_wr & clr_dpr));
        end
    end
endmodule

// File: rtl/pci_cmd_qualify.sv
// Gates decode, mastering and write-command choice by the enables.
// Purely combinational; assumes its inputs come from registered logic.
module pci_cmd_qualify (
    input  logic mem_en,
    input  logic bme,
    input  logic mwi,
    input  logic mem_hit,
    input  logic line_ok,
    input  logic soft_rst,
    input  logic stop_req,
    output logic mem_decode_ok,
    output logic master_ok,
    output logic use_mwi
);
    // Qualify each request by its enable
    always_comb begin
        mem_decode_ok = mem_hit & mem_en;
        master_ok     = bme & ~stop_req & ~soft_rst;
        use_mwi       = line_ok & mwi;
    end
endmodule

// File: rtl/pci_cmd_reg.sv
// Top: configuration command register with its parity error response.
// Assumes a single configuration access per cycle and a synchronous,
// active-low hard reset. Soft reset and stop only affect master_ok.
module pci_cmd_reg
    import pci_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             stop_req,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [BE_W-1:0]  cfg_be,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             addr_perr,
    input  logic             data_perr,
    input  logic             is_master,
    input  logic             mem_hit,
    input  logic             line_ok,
    output logic             fbb_en,
    output logic             serr_en,
    output logic             perr_resp_en,
    output logic             mwi_en,
    output logic             bm_en,
    output logic             mem_en,
    output logic             mem_decode_ok,
    output logic             master_ok,
    output logic             use_mwi,
    output logic             perr_o,
    output logic             serr_o,
    output logic             stat_dpe,
    output logic             stat_dpr,
    output logic             stat_sse
);
    localparam int HI_BYTE = BE_W - 1;

    cmd_en_t          en;
    logic [CFG_W-1:0] cmd_word;
    logic [CFG_W-1:0] stat_word;

    pci_cmd_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr & ~cfg_sel),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .word  (cmd_word),
        .en    (en)
    );

    pci_cmd_errlog u_errlog (
        .clk       (clk),
        .rst_n     (rst_n),
        .pere      (en.pere),
        .serre     (en.serre),
        .addr_perr (addr_perr),
        .data_perr (data_perr),
        .is_master (is_master),
        .clr_wr    (cfg_wr & cfg_sel & cfg_be[HI_BYTE]),
        .clr_dpe   (cfg_wdata[S_DPE]),
        .clr_sse   (cfg_wdata[S_SSE]),
        .clr_dpr   (cfg_wdata[S_DPR]),
        .perr_o    (perr_o),
        .serr_o    (serr_o),
        .dpe       (stat_dpe),
        .sse       (stat_sse),
        .dpr       (stat_dpr)
    );

    pci_cmd_qualify u_qual (
        .mem_en        (en.mem),
        .bme           (en.bme),
        .mwi           (en.mwi),
        .mem_hit       (mem_hit),
        .line_ok       (line_ok),
        .soft_rst      (soft_rst),
        .stop_req      (stop_req),
        .mem_decode_ok (mem_decode_ok),
        .master_ok     (master_ok),
        .use_mwi       (use_mwi)
    );

    // Assemble the status word and select the read data
    always_comb begin
        stat_word        = '0;
        stat_word[S_DPE] = stat_dpe;
        stat_word[S_SSE] = stat_sse;
        stat_word[S_DPR] = stat_dpr;
        cfg_rdata        = cfg_sel ? stat_word : cmd_word;
    end

    // Drive the individual enable outputs
    always_comb begin
        fbb_en       = en.fbb;
        serr_en      = en.serre;
        perr_resp_en = en.pere;
        mwi_en       = en.mwi;
        bm_en        = en.bme;
        mem_en       = en.mem;
    end
endmodule

// File: rtl/pci_cmd_reg_chk.sv
// Checker: temporal properties of the command register, bound to the top.
module pci_cmd_reg_chk (
    input logic clk,
    input logic rst_n,
    input logic soft_rst,
    input logic stop_req,
    input logic cfg_wr,
    input logic addr_perr,
    input logic data_perr,
    input logic fbb_en,
    input logic serr_en,
    input logic perr_resp_en,
    input logic mwi_en,
    input logic bm_en,
    input logic mem_en,
    input logic mem_hit,
    input logic mem_decode_ok,
    input logic master_ok,
    input logic perr_o,
    input logic serr_o,
    input logic stat_dpe
);
    // R6
    perr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> $past(data_perr && perr_resp_en));

    // R8
    serr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> $past(addr_perr && serr_en && perr_resp_en));

    // R5
    detect_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_perr || data_perr) |=> stat_dpe);

    // R4
    enables_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((soft_rst || stop_req) && !cfg_wr) |=>
            $stable({fbb_en, serr_en, perr_resp_en, mwi_en, bm_en, mem_en}));

    // R10
    mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_decode_ok |-> (mem_en && mem_hit));

    // R12
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_ok |-> (bm_en && !stop_req && !soft_rst));
endmodule

bind pci_cmd_reg pci_cmd_reg_chk u_chk (.*);

// File: tb/pci_cmd_reg_bench.sv
`timescale 1ns/1ps
module pci_cmd_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0, stop_req = 1'b0;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        addr_perr = 1'b0, data_perr = 1'b0, is_master = 1'b0;
    logic        mem_hit = 1'b0, line_ok = 1'b0;
    logic        fbb_en, serr_en, perr_resp_en, mwi_en, bm_en, mem_en;
    logic        mem_decode_ok, master_ok, use_mwi;
    logic        perr_o, serr_o, stat_dpe, stat_dpr, stat_sse;

    pci_cmd_reg u_pci_cmd_reg (.*);

    always #2 clk = ~clk;

    typedef struct {
        string       req;
        int          code;
        logic [15:0] exp;
    } item_t;

    item_t       sb_q[$];
    int          checks = 0;
    int          errors = 0;
    logic [15:0] cm = '0;
    logic        m_dpe = 1'b0, m_dpr = 1'b0, m_sse = 1'b0;

    // Observation points by code: 0 read data, 1 status, 2 strobes,
    // 3 qualifiers, 4 enable outputs
    function automatic logic [15:0] observe(input int code);
        case (code)
            0:       return cfg_rdata;
            1:       return {13'b0, stat_dpe, stat_dpr, stat_sse};
            2:       return {14'b0, perr_o, serr_o};
            3:       return {13'b0, mem_decode_ok, master_ok, use_mwi};
            default: return {10'b0, fbb_en, serr_en, perr_resp_en, mwi_en, bm_en, mem_en};
        endcase
    endfunction

    // Monitor: compare queued expectations on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it  = sb_q.pop_front();
                act = observe(it.code);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s code=%0d actual=%h expected=%h", it.req, it.code, act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(input string req, input int code, input logic [15:0] exp);
        item_t it;
        it.req = req; it.code = code; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Let the monitor consume what was pushed
    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic en_vec_exp(input string req);
        expect_v(req, 4, {10'b0, cm[9], cm[8], cm[6], cm[4], cm[2], cm[1]});
    endtask

    task automatic cfg_write(input logic sel, input logic [1:0] be, input logic [15:0] d);
        logic [15:0] m;
        cfg_wr = 1'b1; cfg_sel = sel; cfg_be = be; cfg_wdata = d;
        tick();
        cfg_wr = 1'b0; cfg_be = 2'b00; cfg_wdata = '0;
        m = {{8{be[1]}}, {8{be[0]}}};
        if (!sel) cm = ((cm & ~m) | (d & m)) & 16'h0356;
        else if (be[1]) begin
            if (d[15]) m_dpe = 1'b0;
            if (d[14]) m_sse = 1'b0;
            if (d[8])  m_dpr = 1'b0;
        end
    endtask

    task automatic read_cmd(input string req);
        cfg_sel = 1'b0;
        expect_v(req, 0, cm);
        settle();
    endtask

    task automatic err_pulse(input logic a, input logic d, input logic mst);
        addr_perr = a; data_perr = d; is_master = mst;
        tick();
        addr_perr = 1'b0; data_perr = 1'b0; is_master = 1'b0;
        if (a | d) m_dpe = 1'b1;
        if (d && cm[6] && mst) m_dpr = 1'b1;
        if (a && cm[6] && cm[8]) m_sse = 1'b1;
    endtask

    task automatic status_exp(input string req);
        expect_v(req, 1, {13'b0, m_dpe, m_dpr, m_sse});
    endtask

    bit done = 0;

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state
        read_cmd("R1 cmd after reset");
        status_exp("R1 status after reset");
        expect_v("R1 strobes after reset", 2, 16'h0000);
        settle();

        // R2: all ones write keeps only writable bits
        cfg_write(1'b0, 2'b11, 16'hFFFF);
        read_cmd("R2 reserved bits read zero");
        // R3: byte enables
        cfg_write(1'b0, 2'b01, 16'h0000);
        read_cmd("R3 low byte only");
        cfg_write(1'b0, 2'b10, 16'h0000);
        read_cmd("R3 high byte only");
        cfg_write(1'b0, 2'b00, 16'hFFFF);
        read_cmd("R3 no byte enables");
        cfg_write(1'b0, 2'b01, 16'hFFA9);
        read_cmd("R3 low byte pattern");
        cfg_write(1'b0, 2'b10, 16'h0255);
        read_cmd("R3 high byte pattern");

        // R4: soft reset and stop leave enables
        soft_rst = 1'b1; stop_req = 1'b1;
        tick(); tick();
        soft_rst = 1'b0; stop_req = 1'b0;
        en_vec_exp("R4 enables after soft reset and stop");
        read_cmd("R4 cmd after soft reset and stop");

        // R5/R6: parity response disabled
        cfg_write(1'b0, 2'b11, 16'h0000);
        err_pulse(1'b0, 1'b1, 1'b1);
        expect_v("R6 no PERR when response disabled", 2, 16'h0000);
        status_exp("R5 detected with response disabled");
        settle();

        // R9: write-1-to-clear, low byte only has no effect
        cfg_write(1'b1, 2'b01, 16'hFFFF);
        cfg_sel = 1'b1;
        expect_v("R9 low-byte clear ignored", 0, 16'h8000);
        settle();
        cfg_write(1'b1, 2'b10, 16'hC100);
        status_exp("R9 cleared by W1C");
        settle();

        // R6/R7: response enabled, master cycle
        cfg_write(1'b0, 2'b01, 16'h0040);
        err_pulse(1'b0, 1'b1, 1'b1);
        expect_v("R6 PERR strobe", 2, 16'h0002);
        status_exp("R7 reported on master cycle");
        settle();
        expect_v("R6 PERR one cycle only", 2, 16'h0000);
        settle();
        cfg_write(1'b1, 2'b10, 16'hFFFF);
        err_pulse(1'b0, 1'b1, 1'b0);
        expect_v("R6 PERR on target cycle", 2, 16'h0002);
        status_exp("R7 not reported on target cycle");
        settle();

        // R8: address parity with enable combinations
        cfg_write(1'b1, 2'b10, 16'hFFFF);
        err_pulse(1'b1, 1'b0, 1'b0);
        expect_v("R8 no SERR without SERR enable", 2, 16'h0000);
        status_exp("R8 status with only response enabled");
        settle();
        cfg_write(1'b0, 2'b11, 16'h0100);
        err_pulse(1'b1, 1'b0, 1'b0);
        expect_v("R8 no SERR without response enable", 2, 16'h0000);
        status_exp("R8 status with only SERR enabled");
        settle();
        cfg_write(1'b0, 2'b11, 16'h0140);
        err_pulse(1'b1, 1'b0, 1'b0);
        expect_v("R8 SERR strobe", 2, 16'h0001);
        status_exp("R8 signaled system error set");
        settle();

        // R9: set wins over same-cycle clear
        cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_be = 2'b10; cfg_wdata = 16'hC100;
        addr_perr = 1'b1;
        tick();
        cfg_wr = 1'b0; cfg_be = 2'b00; cfg_wdata = '0; addr_perr = 1'b0;
        m_dpe = 1'b1; m_sse = 1'b1; m_dpr = 1'b0;
        expect_v("R9 status read word", 0, 16'hC000);
        status_exp("R9 set wins over clear");
        settle();

        // R10/R11/R12: qualifiers
        cfg_write(1'b0, 2'b11, 16'h0000);
        mem_hit = 1'b1; line_ok = 1'b1;
        expect_v("R10 R11 R12 all gated off", 3, 16'h0000);
        settle();
        cfg_write(1'b0, 2'b11, 16'h0016);
        expect_v("R10 R11 R12 all enabled", 3, 16'h0007);
        settle();
        stop_req = 1'b1; #1;
        expect_v("R12 stop blocks mastering", 3, 16'h0005);
        settle();
        stop_req = 1'b0; soft_rst = 1'b1; #1;
        expect_v("R12 soft reset blocks mastering", 3, 16'h0005);
        settle();
        soft_rst = 1'b0; mem_hit = 1'b0; line_ok = 1'b0; #1;
        expect_v("R10 R11 no request", 3, 16'h0002);
        settle();

        // R1: hard reset clears everything
        cfg_write(1'b0, 2'b11, 16'hFFFF);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        cm = '0; m_dpe = 1'b0; m_dpr = 1'b0; m_sse = 1'b0;
        en_vec_exp("R1 enables cleared by hard reset");
        status_exp("R1 status cleared by hard reset");
        settle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule